// File: doc/BRIEF.md
# Tag Store with Equality Comparator

This block is a single-port tag memory for a cache controller. Each word holds one 8-bit tag slice. A cycle can do one of four things. It can read a word onto the output bus. It can write a word from the input bus. It can compare the input bus against the stored word and report a mismatch. It can leave the block idle. A separate flush input empties the whole store in a single cycle, for use at power-up or when the cache is invalidated.

The mismatch result models an open-drain line. The block only ever asks for the line to be pulled low. Several instances can therefore be combined with a wired-AND to compare a tag that is wider than one word. The shared data bus is split into an input, an output and an output-drive enable.

All controls are sampled on the rising clock edge. Every output is registered, so each one shows the result of the cycle before. Storage is organised as rows by columns: the upper address bits pick the row and the lower bits pick the column. The default geometry is 128 rows by 16 columns (2048 words). Setting `ROW_W=8` and `COL_W=5` gives the full 256 by 32 (8192 word) arrangement.

Top module: `tag_cmp_store`

## Requirements
- R1: Every address selects its own word. The upper `ROW_W` address bits pick the row and the lower `COL_W` bits pick the column. A value written to one address is read back bit-for-bit unchanged (same polarity), and other addresses are unaffected.
- R2: When `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled, `dout_oe` is 1 in the next cycle and `dout` holds the stored word.
- R3: When `ce_n`=0 and `we_n`=0 are sampled, `din` is stored at `addr`. In the next cycle `dout_oe` is 0 and `match_pull_low` is 0.
- R4: When `ce_n`=0, `we_n`=1 and `oe_n`=1 are sampled, `match_pull_low` in the next cycle is 1 exactly when the stored word differs from `din`, and `dout_oe` is 0.
- R5: When `ce_n`=1 is sampled, no word changes, and in the next cycle `dout_oe` is 0 and `match_pull_low` is 0.
- R6: One cycle with `flush`=1 makes every word read and compare as 0x00 from the next cycle on.
- R7: If `flush`=1 and a write are sampled in the same cycle, the flush wins and the addressed word reads back 0x00.
- R8: During a flush cycle, `dout_oe` and `match_pull_low` still follow the control inputs alone. A read in that cycle returns the contents from before the flush.
- R9: `match_pull_low` is 1 only in compare cycles, so the wired-AND line (`~match_pull_low` ANDed with other devices) is low whenever any device reports a mismatch.
- R10: After reset, `dout_oe`=0, `match_pull_low`=0, and every word reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples all controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| flush | input | 1 | Active-high flash clear of all words |
| addr | input | ROW_W+COL_W | Word address (row in upper bits, column in lower bits) |
| din | input | DW | Data bus input: write data or compare tag |
| dout | output | DW | Data bus output: read data |
| dout_oe | output | 1 | High when the block drives the data bus |
| match_pull_low | output | 1 | High to pull the open-drain match line low (mismatch) |

## Verification
If a valid bit or a stored word is wrong, the error shows up one cycle after the first read or compare of that address. It appears as a wrong `dout` value or a spurious or missing `match_pull_low`. A flush that fails to reach some word shows up as a nonzero read of that word in the cycle after the flush. Because the stimulus keeps returning to a small set of addresses and compares against the model's stored value half the time, a corrupted word surfaces within a few dozen cycles. Control-decode faults show up on `dout_oe` and `match_pull_low` in the very next cycle.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CMP   = 2'd3
    } tcs_op_e;

    // Active-low controls to one operation; write has priority over output enable.
    function automatic tcs_op_e decode_op(input logic ce_n, input logic oe_n, input logic we_n);
        if (ce_n)       return OP_IDLE;
        else if (!we_n) return OP_WRITE;
        else if (!oe_n) return OP_READ;
        else            return OP_CMP;
    endfunction

endpackage

// File: rtl/tcs_decode.sv
module tcs_decode
    import tcs_pkg::*;
(
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output tcs_op_e op
);
    always_comb begin
        op = decode_op(ce_n, oe_n, we_n);
    end
endmodule

// File: rtl/tcs_valid_bits.sv
module tcs_valid_bits #(
    parameter int DEPTH = 2048,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid
);
    logic [DEPTH-1:0] valid_q;

    // Flush wins over a same-cycle set (R7).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    assign look_valid = valid_q[look_idx];
endmodule

// File: rtl/tcs_word_array.sv
module tcs_word_array #(
    parameter int ROW_W = 7,
    parameter int COL_W = 4,
    parameter int DW    = 8,
    localparam int ROWS = 1 << ROW_W,
    localparam int COLS = 1 << COL_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] row_word [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [DW-1:0] cells [COLS];
        logic          row_hit;

        assign row_hit = (row == ROW_W'(r));

        always_ff @(posedge clk) begin
            if (wr_en && row_hit) begin
                cells[col] <= wdata;
            end
        end

        assign row_word[r] = cells[col];
    end

    assign rdata = row_word[row];
endmodule

// File: rtl/tag_cmp_store.sv
module tag_cmp_store
    import tcs_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int COL_W = 4,
    parameter int DW    = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_oe,
    output logic              match_pull_low
);
    typedef struct packed {
        logic [DW-1:0] dout;
        logic          dout_oe;
        logic          pull;
    } out_s;

    out_s    st_d, st_q;
    tcs_op_e op;
    logic    word_valid;
    logic    wr_go;
    logic [DW-1:0] raw_word;
    logic [DW-1:0] stored;

    tcs_decode u_dec (
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .op   (op)
    );

    assign wr_go = (op == OP_WRITE) && !flush;

    tcs_valid_bits #(.DEPTH(DEPTH)) u_valid (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .set_en     (wr_go),
        .set_idx    (addr),
        .look_idx   (addr),
        .look_valid (word_valid)
    );

    tcs_word_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_array (
        .clk   (clk),
        .wr_en (wr_go),
        .row   (addr[ADDR_W-1:COL_W]),
        .col   (addr[COL_W-1:0]),
        .wdata (din),
        .rdata (raw_word)
    );

    // A word never written since the last flush or reset reads as zero.
    assign stored = word_valid ? raw_word : '0;

    always_comb begin
        st_d         = st_q;
        st_d.dout_oe = (op == OP_READ);
        st_d.pull    = (op == OP_CMP) && (stored != din);
        if (op == OP_READ) begin
            st_d.dout = stored;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout           = st_q.dout;
    assign dout_oe        = st_q.dout_oe;
    assign match_pull_low = st_q.pull;
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          flush,
    input logic [DW-1:0] dout,
    input logic          dout_oe,
    input logic          match_pull_low
);
    logic flush_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_seen_q <= 1'b0;
        else        flush_seen_q <= flush;
    end

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_oe);

    assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (!dout_oe && !match_pull_low));

    assert_cmp_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |=> !dout_oe);

    assert_deselect_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dout_oe && !match_pull_low));

    assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_seen_q && !ce_n && !oe_n && we_n) |=> (dout == '0));

    assert_pull_only_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && we_n && oe_n) |=> !match_pull_low);
endmodule

bind tag_cmp_store tcs_checker #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .we_n           (we_n),
    .flush          (flush),
    .dout           (dout),
    .dout_oe        (dout_oe),
    .match_pull_low (match_pull_low)
);

// File: tb/sim_tag_cmp_store.sv
`timescale 1ns/1ps
module sim_tag_cmp_store;
    localparam int ROW_W  = 7;
    localparam int COL_W  = 4;
    localparam int DW     = 8;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, flush = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     din = '0;
    logic [DW-1:0]     dout;
    logic              dout_oe;
    logic              match_pull_low;
    logic              other_pull = 1'b0;
    wire               match_line = ~match_pull_low & ~other_pull;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    tag_cmp_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .flush(flush), .addr(addr), .din(din), .dout(dout),
        .dout_oe(dout_oe), .match_pull_low(match_pull_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_pull(input logic c, input logic o, input logic w,
                                      input logic [DW-1:0] st, input logic [DW-1:0] d);
        return !c && w && o && (st != d);
    endfunction

    // Apply one cycle of controls, then check the registered outputs one cycle later.
    task automatic step(input logic c, input logic o, input logic w, input logic f,
                        input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        logic          e_oe, e_pull;
        logic [DW-1:0] e_dat;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; flush = f; addr = a; din = d;
        e_oe   = !c && !o && w;
        e_dat  = model[a];
        e_pull = exp_pull(c, o, w, model[a], d);
        if (f) begin
            for (int i = 0; i < DEPTH; i++) model[i] = '0;
        end else if (!c && !w) begin
            model[a] = d;
        end
        @(negedge clk);
        ce_n = 1'b1; flush = 1'b0;
        if (c) begin
            check("R5 dout_oe", dout_oe, 0);
            check("R5 pull", match_pull_low, 0);
        end else if (!w) begin
            check("R3 dout_oe", dout_oe, 0);
            check("R3 pull", match_pull_low, 0);
        end else if (!o) begin
            check("R2 dout_oe", dout_oe, e_oe);
            check("R2 dout", dout, e_dat);
            check("R9 pull in read", match_pull_low, 0);
        end else begin
            check("R4 pull", match_pull_low, e_pull);
            check("R4 dout_oe", dout_oe, 0);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);  step(0, 0, 1, 0, a, '0); endtask
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d); step(0, 1, 0, 0, a, d); endtask
    task automatic cmp(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d); step(0, 1, 1, 0, a, d); endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 dout_oe", dout_oe, 0);
        check("R10 pull", match_pull_low, 0);
        rd(11'd5);
        check("R10 word zero", dout, 0);

        // R1 boundaries of rows and columns, polarity kept
        wr('0, 8'hA5);
        wr(DEPTH - 1, 8'h5A);
        wr(11'd15, 8'hF0);
        wr(11'd16, 8'h0F);
        rd('0);        check("R1 addr0", dout, 8'hA5);
        rd(DEPTH - 1); check("R1 last", dout, 8'h5A);
        rd(11'd15);    check("R1 col end", dout, 8'hF0);
        rd(11'd16);    check("R1 next row", dout, 8'h0F);

        // R4 hit and miss, R9 wired-AND
        cmp(11'd16, 8'h0F);
        check("R9 line high on hit", match_line, 1);
        cmp(11'd16, 8'h0E);
        check("R9 line low on miss", match_line, 0);
        other_pull = 1'b1;
        cmp(11'd16, 8'h0F);
        check("R9 line low by other", match_line, 0);
        other_pull = 1'b0;

        // R5 deselected write is ignored
        step(1, 1, 0, 0, 11'd16, 8'hEE);
        rd(11'd16); check("R5 no write", dout, 8'h0F);

        // R8 read during flush returns old content
        step(0, 0, 1, 1, '0, '0);
        check("R8 old data", dout, 8'hA5);
        // R6 all zero after flush
        rd(DEPTH - 1); check("R6 zero", dout, 0);
        cmp(11'd15, 8'h00); check("R6 cmp zero", match_pull_low, 0);

        // R7 flush beats write
        wr(11'd7, 8'h77);
        step(0, 1, 0, 1, 11'd7, 8'h99);
        rd(11'd7); check("R7 flush wins", dout, 0);

        // Random mix over a small address set
        for (int n = 0; n < 4000; n++) begin
            logic [ADDR_W-1:0] a;
            logic [DW-1:0]     d;
            int                k;
            a = ADDR_W'($urandom % 24) + (($urandom % 2) != 0 ? ADDR_W'(DEPTH - 24) : '0);
            k = $urandom % 100;
            d = DW'($urandom);
            if (k < 30)      wr(a, d);
            else if (k < 55) rd(a);
            else if (k < 90) cmp(a, ($urandom % 2) != 0 ? model[a] : d);
            else if (k < 99) step(1, $urandom % 2, $urandom % 2, 0, a, d);
            else             step(0, $urandom % 2, $urandom % 2, 1, a, d);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule